// File: doc/BRIEF.md
# Nibble and Byte Mode Reverse Receiver

This block is the host side of a parallel-port reverse channel. Once started, it fetches a requested number of bytes from an attached peripheral and hands each one out on a valid/ready stream. In nibble mode each byte crosses as two 4-bit transfers carried on four status lines. In byte mode the eight data lines, which the host has already turned to input, carry the whole byte in one transfer. For every transfer the block drives the HostBusy control line and follows the peripheral's PtrClk strobe. Before each byte it checks the active-low data-available line.

A run ends in one of four ways: the requested count is reached, the peripheral has no more data, a PtrClk wait times out, or byte mode is requested while the data lines are still set to output. The block then pulses `done_o` for one cycle. The byte count and the outcome flags stay on their outputs until the next start. Before any decision is made on them, all peripheral inputs pass through a two-flop synchronizer. The timeout length and the width of the HostClk pulse are parameters counted in clock cycles.

On the output stream, a byte is offered with `m_valid` high and stays offered, unchanged, until `m_ready` is seen high at a clock edge. While a byte waits, the engine starts no new handshake, so back-pressure pauses the peripheral. Bytes are counted when they are accepted on the stream.

Top module: `rr_reverse_rx`

## Requirements
- R1: After reset, host_busy_o, host_clk_o, m_valid, busy_o and done_o are 0, and they stay 0 until a start is accepted.
- R2: Before each byte, the synchronized data-available line is sampled. If it is high, the run ends with done_o, early_stop_o=1, no error flag, and rx_count_o equal to the bytes delivered so far.
- R3: In each transfer, host_busy_o rises only while PtrClk is high. It falls after PtrClk has been seen low. The next transfer does not start until PtrClk has been seen high again.
- R4: In nibble mode, the first nibble of a byte forms bits 3:0 and the second forms bits 7:4.
- R5: Each nibble is built as bit0=fault_i, bit1=select_i, bit2=perror_i, bit3=NOT stat_busy_i.
- R6: A start with byte_mode=1 and dir_input=0 is refused. On the next cycle done_o and err_dir_o are 1 and rx_count_o is 0, and HostBusy is never raised.
- R7: In byte mode, the byte is taken from data_i. After PtrClk returns high, host_clk_o is high for exactly PULSE_CYC cycles before the byte is offered on the stream.
- R8: If PtrClk fails to reach the awaited level within TIMEOUT_CYC cycles, the run ends with err_timeout_o=1, and rx_count_o counts the bytes already delivered.
- R9: While m_valid is high and m_ready is low, m_valid stays high and m_data stays unchanged. rx_count_o rises by one on each accepted byte.
- R10: When the requested count is reached, the run ends with done_o and no flag set. A request of 0 ends on the cycle after start with rx_count_o=0.
- R11: A start pulse during a run is ignored, and the run completes with its original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| byte_mode | input | 1 | 1 = byte mode, 0 = nibble mode |
| dir_input | input | 1 | Data-direction control, 1 = data lines are input |
| req_len | input | CNT_W | Number of bytes to fetch |
| ptr_clk_i | input | 1 | Peripheral strobe (PtrClk), active low |
| data_avail_n_i | input | 1 | Peripheral data available, active low |
| fault_i | input | 1 | Fault status line, nibble bit 0 |
| select_i | input | 1 | Select status line, nibble bit 1 |
| perror_i | input | 1 | Paper-error status line, nibble bit 2 |
| stat_busy_i | input | 1 | Busy status bit in host polarity, nibble bit 3 inverted |
| data_i | input | 8 | Data lines, read in byte mode |
| host_busy_o | output | 1 | HostBusy control line |
| host_clk_o | output | 1 | HostClk pulse after each byte-mode byte |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream byte accepted |
| m_data | output | 8 | Stream byte |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| rx_count_o | output | CNT_W | Bytes delivered in the current or last run |
| err_timeout_o | output | 1 | Last run ended on a PtrClk timeout |
| err_dir_o | output | 1 | Last run was refused for direction |
| early_stop_o | output | 1 | Last run ended because no data was available |

## Verification
Every peripheral input reaches the decision logic two cycles late. HostBusy therefore falls about three cycles after PtrClk drops, and the next step follows about three cycles after PtrClk rises. The bench's peripheral model does not rely on a fixed count: it waits at falling edges for HostBusy to change before it moves PtrClk. A refused start shows done_o and err_dir_o one cycle after start, and a zero request also finishes one cycle after start. All other outcomes are read from the held flags and rx_count_o at the falling edge on which done_o is seen. Stream bytes are recorded at the rising edges where both valid and ready are high. HostClk pulses are measured in cycles at falling edges.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_WAIT_LO,
    S_WAIT_HI,
    S_STROBE,
    S_PUSH
  } rr_state_e;

  function automatic logic [3:0] nib_from_status(input logic fault, input logic sel,
                                                 input logic perr, input logic busy);
    return {~busy, perr, sel, fault};
  endfunction
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end
  assign q = stab_q;
endmodule

// File: rtl/rr_timer.sv
module rr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en && (cnt != '1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rr_assembler.sv
module rr_assembler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic       byte_mode,
  input  logic       hi_half,
  input  logic [3:0] nib,
  input  logic [7:0] data,
  output logic [7:0] byte_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_o <= '0;
    else if (cap) begin
      if (byte_mode)    byte_o <= data;
      else if (hi_half) byte_o[7:4] <= nib;
      else              byte_o[3:0] <= nib;
    end
  end
endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 1000,
  parameter int PULSE_CYC   = 100,
  parameter int TW          = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_mode,
  input  logic             dir_input,
  input  logic [CNT_W-1:0] req_len,
  input  logic             ptr_clk_s,
  input  logic             avail_n_s,
  input  logic [TW-1:0]    tcnt,
  input  logic             m_ready,
  output logic             tmr_clr,
  output logic             tmr_en,
  output logic             cap,
  output logic             hi_half,
  output logic             mode_byte,
  output logic             host_busy_o,
  output logic             host_clk_o,
  output logic             m_valid,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             err_timeout_o,
  output logic             err_dir_o,
  output logic             early_stop_o
);
  localparam logic [TW-1:0] TMO_LAST   = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_CYC - 1);

  rr_state_e state_q, state_d;
  logic [CNT_W-1:0] req_q, cnt_q;
  logic mode_q, nib_hi_q;
  logic tmo, pulse_end;

  assign tmo       = (tcnt == TMO_LAST);
  assign pulse_end = (tcnt == PULSE_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start && !(byte_mode && !dir_input) && (req_len != '0)) state_d = S_CHECK;
      S_CHECK:   state_d = avail_n_s ? S_IDLE : S_WAIT_LO;
      S_WAIT_LO: if (!ptr_clk_s) state_d = S_WAIT_HI;
                 else if (tmo)   state_d = S_IDLE;
      S_WAIT_HI: if (ptr_clk_s) begin
                   if (mode_q)        state_d = S_STROBE;
                   else if (nib_hi_q) state_d = S_PUSH;
                   else               state_d = S_WAIT_LO;
                 end else if (tmo) state_d = S_IDLE;
      S_STROBE:  if (pulse_end) state_d = S_PUSH;
      S_PUSH:    if (m_ready) state_d = ((cnt_q + 1'b1) == req_q) ? S_IDLE : S_CHECK;
      default:   state_d = S_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);
  assign tmr_en  = (state_q == S_WAIT_LO) || (state_q == S_WAIT_HI) || (state_q == S_STROBE);
  assign cap     = (state_q == S_WAIT_LO) && !ptr_clk_s;
  assign hi_half = nib_hi_q;
  assign mode_byte = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= S_IDLE;
      req_q         <= '0;
      cnt_q         <= '0;
      mode_q        <= 1'b0;
      nib_hi_q      <= 1'b0;
      done_o        <= 1'b0;
      err_timeout_o <= 1'b0;
      err_dir_o     <= 1'b0;
      early_stop_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start) begin
          req_q         <= req_len;
          mode_q        <= byte_mode;
          cnt_q         <= '0;
          err_timeout_o <= 1'b0;
          early_stop_o  <= 1'b0;
          err_dir_o     <= byte_mode && !dir_input;
          if ((byte_mode && !dir_input) || (req_len == '0)) done_o <= 1'b1;
        end
        S_CHECK: begin
          nib_hi_q <= 1'b0;
          if (avail_n_s) begin
            early_stop_o <= 1'b1;
            done_o       <= 1'b1;
          end
        end
        S_WAIT_LO: if (ptr_clk_s && tmo) begin
          err_timeout_o <= 1'b1;
          done_o        <= 1'b1;
        end
        S_WAIT_HI: begin
          if (ptr_clk_s) begin
            if (!mode_q && !nib_hi_q) nib_hi_q <= 1'b1;
          end else if (tmo) begin
            err_timeout_o <= 1'b1;
            done_o        <= 1'b1;
          end
        end
        S_PUSH: if (m_ready) begin
          cnt_q <= cnt_q + 1'b1;
          if ((cnt_q + 1'b1) == req_q) done_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign host_busy_o = (state_q == S_WAIT_LO);
  assign host_clk_o  = (state_q == S_STROBE);
  assign m_valid     = (state_q == S_PUSH);
  assign busy_o      = (state_q != S_IDLE);
  assign rx_count_o  = cnt_q;
endmodule

// File: rtl/rr_reverse_rx.sv
module rr_reverse_rx
  import rr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TIMEOUT_CYC = 1000,
  parameter int PULSE_CYC   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             byte_mode,
  input  logic             dir_input,
  input  logic [CNT_W-1:0] req_len,
  input  logic             ptr_clk_i,
  input  logic             data_avail_n_i,
  input  logic             fault_i,
  input  logic             select_i,
  input  logic             perror_i,
  input  logic             stat_busy_i,
  input  logic [7:0]       data_i,
  output logic             host_busy_o,
  output logic             host_clk_o,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [7:0]       m_data,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic             err_timeout_o,
  output logic             err_dir_o,
  output logic             early_stop_o
);
  localparam int MAXC = (TIMEOUT_CYC > PULSE_CYC) ? TIMEOUT_CYC : PULSE_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int SW   = 14;

  logic [SW-1:0] raw_in, syn_in;
  logic ptr_clk_s, avail_n_s;
  logic [3:0] nib_s;
  logic [7:0] data_s;
  logic [TW-1:0] tcnt;
  logic tmr_clr, tmr_en, cap, hi_half, mode_byte;

  assign raw_in = {ptr_clk_i, data_avail_n_i, fault_i, select_i, perror_i, stat_busy_i, data_i};

  rr_sync #(.W(SW), .RST_VAL({2'b11, 12'h000})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign ptr_clk_s = syn_in[13];
  assign avail_n_s = syn_in[12];
  assign nib_s     = nib_from_status(syn_in[11], syn_in[10], syn_in[9], syn_in[8]);
  assign data_s    = syn_in[7:0];

  rr_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en), .cnt(tcnt)
  );

  rr_assembler u_asm (
    .clk(clk), .rst_n(rst_n), .cap(cap), .byte_mode(mode_byte), .hi_half(hi_half),
    .nib(nib_s), .data(data_s), .byte_o(m_data)
  );

  rr_ctrl #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC), .PULSE_CYC(PULSE_CYC), .TW(TW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode), .dir_input(dir_input),
    .req_len(req_len), .ptr_clk_s(ptr_clk_s), .avail_n_s(avail_n_s), .tcnt(tcnt),
    .m_ready(m_ready), .tmr_clr(tmr_clr), .tmr_en(tmr_en), .cap(cap), .hi_half(hi_half),
    .mode_byte(mode_byte), .host_busy_o(host_busy_o), .host_clk_o(host_clk_o),
    .m_valid(m_valid), .busy_o(busy_o), .done_o(done_o), .rx_count_o(rx_count_o),
    .err_timeout_o(err_timeout_o), .err_dir_o(err_dir_o), .early_stop_o(early_stop_o)
  );
endmodule

// File: rtl/rr_reverse_rx_chk.sv
module rr_reverse_rx_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             byte_mode,
  input logic             dir_input,
  input logic             ptr_clk_s,
  input logic             host_busy_o,
  input logic             host_clk_o,
  input logic             m_valid,
  input logic             m_ready,
  input logic [7:0]       m_data,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic             err_timeout_o,
  input logic             err_dir_o,
  input logic             early_stop_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!host_busy_o && !host_clk_o && !m_valid));

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy_o) |-> ptr_clk_s);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy_o |-> (!host_clk_o && !m_valid));

  p_dir_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o && byte_mode && !dir_input) |=> (done_o && err_dir_o && !busy_o));

  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({err_timeout_o, err_dir_o, early_stop_o}) <= 1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count_o != $past(rx_count_o)) |-> ((rx_count_o == $past(rx_count_o) + 1'b1) || (rx_count_o == '0)));
endmodule

bind rr_reverse_rx rr_reverse_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode), .dir_input(dir_input),
  .ptr_clk_s(ptr_clk_s), .host_busy_o(host_busy_o), .host_clk_o(host_clk_o),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .busy_o(busy_o), .done_o(done_o),
  .rx_count_o(rx_count_o), .err_timeout_o(err_timeout_o), .err_dir_o(err_dir_o),
  .early_stop_o(early_stop_o)
);

// File: tb/rr_reverse_rx_tb.sv
`timescale 1ns/1ps
module rr_reverse_rx_tb_top;
  localparam int PULSE = 100;
  localparam int TMO   = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, byte_mode = 1'b0, dir_input = 1'b0;
  logic [7:0] req_len = '0;
  logic ptr_clk_i = 1'b1, data_avail_n_i = 1'b1;
  logic fault_i = 0, select_i = 0, perror_i = 0, stat_busy_i = 0;
  logic [7:0] data_i = '0;
  logic host_busy_o, host_clk_o, m_valid, m_ready, busy_o, done_o;
  logic [7:0] m_data, rx_count_o;
  logic err_timeout_o, err_dir_o, early_stop_o;

  always #5 clk = ~clk;

  rr_reverse_rx #(.CNT_W(8), .TIMEOUT_CYC(TMO), .PULSE_CYC(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode), .dir_input(dir_input),
    .req_len(req_len), .ptr_clk_i(ptr_clk_i), .data_avail_n_i(data_avail_n_i),
    .fault_i(fault_i), .select_i(select_i), .perror_i(perror_i), .stat_busy_i(stat_busy_i),
    .data_i(data_i), .host_busy_o(host_busy_o), .host_clk_o(host_clk_o), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .busy_o(busy_o), .done_o(done_o),
    .rx_count_o(rx_count_o), .err_timeout_o(err_timeout_o), .err_dir_o(err_dir_o),
    .early_stop_o(early_stop_o)
  );

  int checks = 0, errors = 0;
  logic [7:0] pbytes [16];
  int p_navail = 0, p_stall_at = -1, p_xfer = 0;
  logic p_bm = 1'b0;
  logic [7:0] got [16];
  int got_n = 0;
  logic bp_en = 1'b0;
  int cyc = 0;
  int hb_rises = 0, hb_bad = 0, hc_len = 0, hc_pulses = 0, hc_bad = 0;
  logic hb_prev = 1'b0, hc_prev = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stream sink and back-pressure
  always @(posedge clk) if (m_valid && m_ready && got_n < 16) begin
    got[got_n] = m_data;
    got_n++;
  end
  always @(negedge clk) begin
    cyc++;
    m_ready <= bp_en ? (cyc % 4 == 0) : 1'b1;
  end

  // handshake and pulse monitors
  always @(negedge clk) begin
    if (host_busy_o && !hb_prev) begin
      hb_rises++;
      if (!ptr_clk_i) hb_bad++;
    end
    hb_prev = host_busy_o;
    if (host_clk_o) hc_len++;
    else if (hc_prev) begin
      hc_pulses++;
      if (hc_len != PULSE) hc_bad++;
      hc_len = 0;
    end
    hc_prev = host_clk_o;
  end

  // peripheral model
  initial begin
    forever begin
      @(negedge clk);
      if (host_busy_o) begin
        if (p_xfer == p_stall_at) begin
          while (host_busy_o) @(negedge clk);
        end else begin
          logic [7:0] b;
          logic [3:0] n;
          b = pbytes[p_bm ? p_xfer : (p_xfer / 2)];
          n = p_xfer[0] ? b[7:4] : b[3:0];
          if (p_bm) data_i = b;
          else begin
            fault_i = n[0]; select_i = n[1]; perror_i = n[2]; stat_busy_i = ~n[3];
          end
          repeat (3) @(negedge clk);
          ptr_clk_i = 1'b0;
          while (host_busy_o) @(negedge clk);
          repeat (2) @(negedge clk);
          ptr_clk_i = 1'b1;
          p_xfer++;
          if (p_bm) data_avail_n_i = (p_xfer >= p_navail);
          else if (p_xfer % 2 == 0) data_avail_n_i = ((p_xfer / 2) >= p_navail);
        end
      end
    end
  end

  task automatic setup(input logic bm, input int navail, input int stall_at, input logic bp);
    p_bm = bm; p_navail = navail; p_stall_at = stall_at; p_xfer = 0;
    data_avail_n_i = (navail == 0);
    ptr_clk_i = 1'b1;
    bp_en = bp;
    got_n = 0; hc_pulses = 0; hc_bad = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic bm, input logic dir, input int n);
    int lim;
    @(negedge clk);
    byte_mode = bm; dir_input = dir; req_len = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = 0;
    while (!done_o && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    if (!done_o) chk("run done seen", 0, 1);
  endtask

  task automatic t_reset;
    chk("R1 host_busy", host_busy_o, 0);
    chk("R1 host_clk", host_clk_o, 0);
    chk("R1 m_valid", m_valid, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  task automatic t_nibble_basic;
    pbytes[0] = 8'hA5; pbytes[1] = 8'h3C; pbytes[2] = 8'hF0;
    setup(1'b0, 3, -1, 1'b0);
    run(1'b0, 1'b0, 3);
    chk("R10 count", rx_count_o, 3);
    chk("R10 flags", {err_timeout_o, err_dir_o, early_stop_o}, 0);
    chk("R4 got_n", got_n, 3);
    for (int i = 0; i < 3; i++) chk("R4 R5 nibble byte", got[i], pbytes[i]);
  endtask

  task automatic t_nibble_bp;
    pbytes[0] = 8'h81; pbytes[1] = 8'h7E;
    setup(1'b0, 2, -1, 1'b1);
    run(1'b0, 1'b0, 2);
    chk("R9 count", rx_count_o, 2);
    chk("R5 bit map 81", got[0], 8'h81);
    chk("R5 bit map 7E", got[1], 8'h7E);
    chk("R3 handshake", hb_bad, 0);
  endtask

  task automatic t_byte_mode;
    pbytes[0] = 8'h12; pbytes[1] = 8'hED; pbytes[2] = 8'h00; pbytes[3] = 8'hFF;
    setup(1'b1, 4, -1, 1'b1);
    run(1'b1, 1'b1, 4);
    chk("R7 count", rx_count_o, 4);
    for (int i = 0; i < 4; i++) chk("R7 byte", got[i], pbytes[i]);
    chk("R7 pulses", hc_pulses, 4);
    chk("R7 pulse width", hc_bad, 0);
  endtask

  task automatic t_dir_refuse;
    int r0;
    setup(1'b1, 4, -1, 1'b0);
    r0 = hb_rises;
    @(negedge clk);
    byte_mode = 1'b1; dir_input = 1'b0; req_len = 8'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 done", done_o, 1);
    chk("R6 err_dir", err_dir_o, 1);
    chk("R6 count", rx_count_o, 0);
    repeat (20) @(negedge clk);
    chk("R6 no host_busy", hb_rises - r0, 0);
  endtask

  task automatic t_early_stop;
    pbytes[0] = 8'h5A; pbytes[1] = 8'hC3;
    setup(1'b0, 2, -1, 1'b0);
    run(1'b0, 1'b0, 5);
    chk("R2 count", rx_count_o, 2);
    chk("R2 early_stop", early_stop_o, 1);
    chk("R2 no timeout", err_timeout_o, 0);
    setup(1'b0, 0, -1, 1'b0);
    run(1'b0, 1'b0, 3);
    chk("R2 count none", rx_count_o, 0);
    chk("R2 early_stop none", early_stop_o, 1);
  endtask

  task automatic t_timeout;
    pbytes[0] = 8'h96; pbytes[1] = 8'h69;
    setup(1'b0, 2, 3, 1'b0);
    run(1'b0, 1'b0, 2);
    chk("R8 err_timeout", err_timeout_o, 1);
    chk("R8 count", rx_count_o, 1);
    chk("R8 got byte", got[0], 8'h96);
    chk("R8 early_stop clear", early_stop_o, 0);
  endtask

  task automatic t_zero_req;
    setup(1'b0, 4, -1, 1'b0);
    @(negedge clk);
    byte_mode = 1'b0; req_len = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 zero done", done_o, 1);
    chk("R10 zero count", rx_count_o, 0);
    chk("R10 zero busy", busy_o, 0);
  endtask

  task automatic t_restart_ignored;
    pbytes[0] = 8'h11; pbytes[1] = 8'h22; pbytes[2] = 8'h33; pbytes[3] = 8'h44;
    setup(1'b0, 4, -1, 1'b0);
    fork
      run(1'b0, 1'b0, 2);
      begin
        while (!host_busy_o) @(negedge clk);
        req_len = 8'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk("R11 count", rx_count_o, 2);
    chk("R11 got_n", got_n, 2);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_nibble_basic();
    t_nibble_bp();
    t_byte_mode();
    t_dir_refuse();
    t_early_stop();
    t_timeout();
    t_zero_req();
    t_restart_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule